// File: doc/BRIEF.md
# UART Baud Tick Generator

This block turns a fixed reference clock into two enable pulses for a serial transmitter and receiver. The sample tick marks the oversampling instants. The bit tick marks the boundaries of serial bits. The source clock is either the reference clock itself or the reference clock divided by eight. A clock divisor counter cuts the source down to the sample rate. A second counter then cuts the sample rate down to the bit rate. The resulting bit period is divisor × (bit divider + 1) source cycles.

Software sets three settings through a write-only port: the mode word, the divisor and the bit divider. A write that would put either divider below its legal floor is dropped, and the stored value stays as it was. A new divider value waits until the running count wraps, so no period is ever cut short. A change of the source selection restarts the whole chain, which gives a known phase afterwards.

Top module: `ubg_top`

## Requirements
- R1: While reset is asserted, and until the first full sample period has elapsed after it, `sample_tick` and `bit_tick` stay low.
- R2: After reset the divisor is 0x28B (651) and the bit divider is 0x0F, so sample ticks come every 651 cycles and bit ticks every 10416 cycles.
- R3: In steady state `sample_tick` pulses once every divisor source cycles, and `bit_tick` pulses once every divisor × (bit divider + 1) source cycles. With a divisor of 1, `sample_tick` is high on every source cycle.
- R4: A write to address 1 sets the divisor to `wr_data[15:0]`. The write is ignored if the whole value is 0 or if those kept 16 bits are 0.
- R5: A write to address 2 sets the bit divider to `wr_data[7:0]`. The write is ignored if the whole value is below 4 or if those kept 8 bits are below 4.
- R6: A write to address 0 sets the source selection from `wr_data[0]`: 1 selects the reference clock divided by 8, and 0 selects the reference clock. All other bits of that write are ignored.
- R7: A write to address 0 that changes bit 0 restarts the prescaler and both counters, using the current divisor and bit divider. In the cycle after that write edge neither tick is high. With the undivided source, the first sample tick follows that edge by divisor cycles, and the first bit tick follows it by divisor × (bit divider + 1) + 1 cycles.
- R8: A divisor or bit-divider write does not change the period in progress. It takes effect at the next wrap of that counter.
- R9: Each tick is one cycle wide. `bit_tick` is high exactly one cycle after a `sample_tick` cycle.
- R10: Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | 2 | Write target: 0 mode, 1 divisor, 2 bit divider, 3 none |
| wr_data | input | 32 | Write value |
| sample_tick | output | 1 | One-cycle pulse per sample period |
| bit_tick | output | 1 | One-cycle pulse per bit period |

## Verification
A wrong count, a wrong stored limit or a wrong prescaler phase shows up directly as a wrong spacing between ticks. The error is visible within one sample or bit period of the fault, so the bench measures tick intervals against values computed from the requirements. A lost or early reload shows up on the first period after a divisor write, and the bench checks that period to the exact cycle. The restart is checked by counting the cycles from the mode-write edge to the first tick of each kind. An accepted illegal write, or an accepted write to address 3, shows up as a changed period in the following interval measurement.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
  localparam int DATA_WIDTH = 32;
  localparam int CD_WIDTH   = 16;
  localparam int BD_WIDTH   = 8;
  localparam int CD_RESET   = 32'h0000_028B;
  localparam int BD_RESET   = 32'h0000_000F;
  localparam int CD_FLOOR   = 1;
  localparam int BD_FLOOR   = 4;
  localparam int PRESCALE   = 8;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_CD   = 2'd1,
    SEL_BD   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ubg_cfg.sv
module ubg_cfg
  import ubg_pkg::*;
#(
  parameter int DATA_W = DATA_WIDTH,
  parameter int CD_W   = CD_WIDTH,
  parameter int BD_W   = BD_WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              div8_o,
  output logic [CD_W-1:0]   cd_o,
  output logic [BD_W-1:0]   bd_o,
  output logic              restart_o
);
  logic            mode_q, mode_d, mode_we;
  logic [CD_W-1:0] cd_q, cd_keep;
  logic [BD_W-1:0] bd_q, bd_keep;
  logic            cd_we, bd_we;

  always_comb begin
    cd_keep   = wr_data[CD_W-1:0];
    bd_keep   = wr_data[BD_W-1:0];
    mode_we   = wr_en && (wr_addr == SEL_MODE);
    mode_d    = wr_data[0];
    cd_we     = wr_en && (wr_addr == SEL_CD)
                && (wr_data >= DATA_W'(CD_FLOOR))
                && (cd_keep >= CD_W'(CD_FLOOR));
    bd_we     = wr_en && (wr_addr == SEL_BD)
                && (wr_data >= DATA_W'(BD_FLOOR))
                && (bd_keep >= BD_W'(BD_FLOOR));
    restart_o = mode_we && (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cd_q   <= CD_W'(CD_RESET);
      bd_q   <= BD_W'(BD_RESET);
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (cd_we)   cd_q   <= cd_keep;
      if (bd_we)   bd_q   <= bd_keep;
    end
  end

  assign div8_o = mode_q;
  assign cd_o   = cd_q;
  assign bd_o   = bd_q;

  a_r4_zero_cd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_CD && wr_data == '0) |=> $stable(cd_q));
  a_r5_low_bd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_BD && wr_data < DATA_W'(BD_FLOOR)) |=> $stable(bd_q));
  a_r10_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_NONE) |=> ($stable(cd_q) && $stable(bd_q) && $stable(mode_q)));
endmodule

// File: rtl/ubg_prescale.sv
module ubg_prescale #(
  parameter int RATIO = 8,
  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic div8_i,
  output logic en_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  always_comb begin
    last = (cnt_q == CNT_W'(RATIO - 1));
    if (restart_i || !div8_i || last) cnt_d = '0;
    else                              cnt_d = cnt_q + 1'b1;
    en_o = div8_i ? last : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r6_div8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (div8_i && $past(div8_i) && en_o) |=> (!div8_i || !en_o));
endmodule

// File: rtl/ubg_divider.sv
module ubg_divider #(
  parameter int W       = 16,
  parameter int RST_LIM = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d, act_q, act_d;
  logic         tick_q, tick_d, wrap, act_ld;

  always_comb begin
    wrap   = en_i && (cnt_q == act_q - 1'b1);
    act_ld = restart_i || wrap;
    act_d  = act_ld ? lim_i : act_q;
    tick_d = 1'b0;
    cnt_d  = cnt_q;
    if (restart_i) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else if (en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= W'(RST_LIM);
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
      if (act_ld) act_q <= act_d;
    end
  end

  assign tick_o = tick_q;

  a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && act_q > W'(1)) |=> !tick_q);
endmodule

// File: rtl/ubg_top.sv
module ubg_top
  import ubg_pkg::*;
#(
  parameter int DATA_W = DATA_WIDTH,
  parameter int CD_W   = CD_WIDTH,
  parameter int BD_W   = BD_WIDTH,
  parameter int PRE    = PRESCALE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam int BL_W = BD_W + 1;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            div8, restart, src_en;
  logic [CD_W-1:0] cd;
  logic [BD_W-1:0] bd;
  logic [BL_W-1:0] bit_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ubg_cfg #(.DATA_W(DATA_W), .CD_W(CD_W), .BD_W(BD_W)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div8_o(div8), .cd_o(cd), .bd_o(bd),
    .restart_o(restart)
  );

  ubg_prescale #(.RATIO(PRE)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .restart_i(restart), .div8_i(div8),
    .en_o(src_en)
  );

  assign bit_lim = {1'b0, bd} + BL_W'(1);

  ubg_divider #(.W(CD_W), .RST_LIM(CD_RESET)) u_sdiv (
    .clk(clk), .rst_n(rst_int_n), .restart_i(restart), .en_i(src_en),
    .lim_i(cd), .tick_o(sample_tick)
  );

  ubg_divider #(.W(BL_W), .RST_LIM(BD_RESET + 1)) u_bdiv (
    .clk(clk), .rst_n(rst_int_n), .restart_i(restart), .en_i(sample_tick),
    .lim_i(bit_lim), .tick_o(bit_tick)
  );

  a_r9_bit_after_sample: assert property (@(posedge clk) disable iff (!rst_int_n)
    bit_tick |-> $past(sample_tick));
  a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    restart |=> (!sample_tick && !bit_tick));
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> (!sample_tick && !bit_tick));
endmodule

// File: tb/sim_ubg_top.sv
`timescale 1ns/1ps
module sim_ubg_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        sample_tick, bit_tick;

  always #2 clk = ~clk;

  ubg_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  typedef struct { int sp; int bp; string tag; } exp_t;
  exp_t exp_q[$];
  int n_push = 0, n_done = 0;
  int total = 0, bad = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_bits(input int n);
    repeat (n) begin
      do @(negedge clk); while (!bit_tick);
    end
  endtask

  task automatic config_set(input logic [31:0] cd, input logic [31:0] bd, input logic [31:0] md);
    wr(2'd1, cd); wr(2'd2, bd); wr(2'd0, md);
    wait_bits(2);
  endtask

  task automatic expect_per(input int sp, input int bp, input string tag);
    exp_t e;
    e.sp = sp; e.bp = bp; e.tag = tag;
    exp_q.push_back(e);
    n_push++;
    wait (n_done == n_push);
  endtask

  task automatic meas(input bit which, output int per);
    int t0;
    do @(negedge clk); while (!(which ? bit_tick : sample_tick));
    t0 = cyc;
    do @(negedge clk); while (!(which ? bit_tick : sample_tick));
    per = cyc - t0;
  endtask

  // monitor: pops expected periods and compares them with measured tick spacing
  initial begin
    forever begin
      exp_t e;
      int p;
      wait (n_push > n_done);
      e = exp_q.pop_front();
      meas(1'b0, p);
      check(p == e.sp, {e.tag, " sample period"}, p, e.sp);
      meas(1'b1, p);
      check(p == e.bp, {e.tag, " bit period"}, p, e.bp);
      n_done++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0;
    bit prev;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
    // R1: quiet during reset
    repeat (5) @(negedge clk);
    check(!sample_tick && !bit_tick, "R1 in reset", {sample_tick, bit_tick}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(!sample_tick && !bit_tick, "R1 after release", {sample_tick, bit_tick}, 0);

    // R2: reset divider values
    expect_per(651, 651 * 16, "R2");

    // R3: formula and CD=1 boundary
    config_set(3, 4, 0);
    expect_per(3, 15, "R3");
    config_set(1, 4, 0);
    expect_per(1, 5, "R3 cd1");

    // R4: zero and zero-after-truncation divisor writes ignored
    wr(2'd1, 32'h0);
    wr(2'd1, 32'h0001_0000);
    wait_bits(2);
    expect_per(1, 5, "R4 ignored");

    // R5 and R10: low bit-divider writes and address 3 ignored
    wr(2'd2, 32'h3);
    wr(2'd2, 32'h102);
    wr(2'd3, 32'h0);
    wr(2'd3, 32'h1);
    wait_bits(2);
    expect_per(1, 5, "R5 R10 ignored");

    // R4 R5: legal writes keep low bits only
    config_set(32'h0003_0005, 32'h1FF, 0);
    expect_per(5, 1280, "R4 R5 truncate");

    // R6: prescaler select, other mode bits ignored
    config_set(2, 4, 1);
    expect_per(16, 80, "R6 div8");
    wr(2'd0, 32'hFFFF_FFFE);
    wait_bits(2);
    expect_per(2, 10, "R6 undivided");

    // R7: restart timing on mode change 1 -> 0 with cd=3 bd=4
    config_set(3, 4, 1);
    wr(2'd0, 32'h0);
    t0 = cyc;
    check(!sample_tick && !bit_tick, "R7 quiet after restart", {sample_tick, bit_tick}, 0);
    do @(negedge clk); while (!sample_tick);
    check(cyc - t0 == 3, "R7 first sample", cyc - t0, 3);
    while (!bit_tick) @(negedge clk);
    check(cyc - t0 == 16, "R7 first bit", cyc - t0, 16);

    // R9: bit tick one cycle after a sample tick, one cycle wide
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (bit_tick) break;
      prev = sample_tick;
    end
    check(prev && !sample_tick, "R9 alignment", {prev, sample_tick}, 2);
    @(negedge clk);
    check(!bit_tick, "R9 width", bit_tick, 0);

    // R8: new divisor waits for the reload
    config_set(20, 4, 0);
    do @(negedge clk); while (!sample_tick);
    t0 = cyc;
    repeat (4) @(negedge clk);
    wr(2'd1, 32'd2);
    do @(negedge clk); while (!sample_tick);
    check(cyc - t0 == 20, "R8 period in progress", cyc - t0, 20);
    t0 = cyc;
    do @(negedge clk); while (!sample_tick);
    check(cyc - t0 == 2, "R8 after reload", cyc - t0, 2);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule